// File: doc/BRIEF.md
# Flash Command Shift Engine

This block is a small SPI master for serial flash devices. Software loads three registers: a control word, a command word, and a data word. A single write to the control word with its launch bit set then runs one complete command frame on the serial pins. During the frame the engine pulls chip select low and sends the transmit bytes. These are, in order, the command byte, the address bytes and the outgoing data bytes, all taken from one byte stream. A single transmit count covers the whole stream. After the last transmit byte the engine clocks in the requested number of reply bytes and then releases chip select.

Reply bytes land in the data register in little-endian order, so the first byte received sits in the lowest byte lane. A busy flag in the control word stays set from the launch until chip select is high again. While the flag is set, register writes have no effect. The serial clock is a fixed division of the system clock, and only SPI mode 0 with a single target is supported.

Top module: `flash_cmd_shifter`

## Requirements
- R1: Register map on `reg_addr`: 0 is control, 1 is command, 2 is data. Control fields are transmit count in bits 3:0, receive count in bits 7:4, launch in bit 8 (always reads 0) and busy in bit 16 (read only). The command word holds the command byte in bits 7:0 and a 24-bit address in bits 31:8. After reset all registers read 0, `spi_cs_n` is 1, and `spi_sck` and `spi_mosi` are 0.
- R2: A control write with bit 8 set, made while idle and with a non-zero byte total, starts a frame. Busy reads 1 from the cycle after the write until `spi_cs_n` has returned high.
- R3: The frame sends exactly transmit-count bytes, taken from the stream command byte, address bits 23:16, address bits 15:8, address bits 7:0, data bits 7:0, 15:8, 23:16, 31:24.
- R4: Each byte goes out most significant bit first. `spi_sck` idles low. `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled on the rising edge.
- R5: Reply bytes are clocked only after all transmit bytes. `spi_mosi` is 0 while they are clocked, and a frame has exactly 8 × (transmit + receive) rising clock edges.
- R6: Reply byte j is written to data bits 8j+7:8j. Lanes at or above the receive count keep their previous value.
- R7: A written transmit count above 8 reads back as 8, and a written receive count above 4 reads back as 4.
- R8: While busy, writes to any register are ignored. Counts, command and data are unchanged, and no second frame starts.
- R9: A launch with both counts zero starts no frame. Busy stays 0 and `spi_cs_n` stays high.
- R10: Each clock phase lasts HALF_DIV system cycles. The first rising edge comes HALF_DIV cycles after `spi_cs_n` falls, and `spi_cs_n` rises HALF_DIV cycles after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong bit counter or byte index in the engine becomes visible on the pins within the same frame. The captured command or address byte differs, the number of clock pulses departs from eight per byte, or chip select rises early or late against the last falling clock edge. A wrong lane pointer or a receive capture on the wrong edge shows up as a data register readback that differs from the reply pattern as soon as busy clears. The busy gating is observable through control readback after the frame: stale or altered counts, or a second burst of clock pulses, reveal that a mid-frame write slipped through.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   // register select codes
   localparam logic [1:0] RA_CTRL = 2'd0;
   localparam logic [1:0] RA_CMD  = 2'd1;
   localparam logic [1:0] RA_DATA = 2'd2;

   // control word layout
   localparam int unsigned F_TX_LSB = 0;
   localparam int unsigned F_RX_LSB = 4;
   localparam int unsigned F_CNT_W  = 4;
   localparam int unsigned F_START  = 8;
   localparam int unsigned F_BUSY   = 16;

   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_LOW  = 2'd1,
      SH_HIGH = 2'd2,
      SH_TAIL = 2'd3
   } shift_state_e;

endpackage

// File: rtl/fcs_halfclk.sv
module fcs_halfclk #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt_q;

         assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || tick) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fcs_regfile.sv
module fcs_regfile
   import fcs_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 3,
   parameter int unsigned DATA_BYTES = 4,
   parameter int unsigned MAX_TX     = 8,
   parameter int unsigned TXW        = 4,
   parameter int unsigned RXW        = 3,
   parameter int unsigned LANEW      = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [1:0]                addr,
   input  logic [31:0]               wdata,
   output logic [31:0]               rdata,
   input  logic                      eng_busy,
   output logic                      busy_flag,
   output logic                      go,
   output logic [TXW-1:0]            tx_cnt,
   output logic [RXW-1:0]            rx_cnt,
   output logic [8*(1+ADDR_BYTES)-1:0] cmd_q,
   output logic [8*DATA_BYTES-1:0]   data_q,
   input  logic                      lane_we,
   input  logic [LANEW-1:0]          lane_idx,
   input  logic [7:0]                lane_byte
);

   localparam int unsigned CMDW = 8 * (1 + ADDR_BYTES);
   localparam int unsigned DATW = 8 * DATA_BYTES;

   logic [F_CNT_W-1:0] tx_in, rx_in;
   logic [TXW-1:0]     tx_lim;
   logic [RXW-1:0]     rx_lim;
   logic [31:0]        ctrl_rd;

   assign busy_flag = go | eng_busy;

   assign tx_in  = wdata[F_TX_LSB +: F_CNT_W];
   assign rx_in  = wdata[F_RX_LSB +: F_CNT_W];
   assign tx_lim = (32'(tx_in) > MAX_TX)     ? TXW'(MAX_TX)     : tx_in[TXW-1:0];
   assign rx_lim = (32'(rx_in) > DATA_BYTES) ? RXW'(DATA_BYTES) : rx_in[RXW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go     <= 1'b0;
         tx_cnt <= '0;
         rx_cnt <= '0;
         cmd_q  <= '0;
         data_q <= '0;
      end else begin
         go <= 1'b0;
         if (wr_en && !busy_flag) begin
            case (addr)
               RA_CTRL: begin
                  tx_cnt <= tx_lim;
                  rx_cnt <= rx_lim;
                  go     <= wdata[F_START] && ((tx_lim != '0) || (rx_lim != '0));
               end
               RA_CMD:  cmd_q  <= wdata[CMDW-1:0];
               RA_DATA: data_q <= wdata[DATW-1:0];
               default: ;
            endcase
         end
         if (lane_we) begin
            data_q[8*lane_idx +: 8] <= lane_byte;
         end
      end
   end

   always_comb begin
      ctrl_rd                    = '0;
      ctrl_rd[F_TX_LSB +: TXW]   = tx_cnt;
      ctrl_rd[F_RX_LSB +: RXW]   = rx_cnt;
      ctrl_rd[F_BUSY]            = busy_flag;
   end

   always_comb begin
      case (addr)
         RA_CTRL: rdata = ctrl_rd;
         RA_CMD:  rdata = 32'(cmd_q);
         RA_DATA: rdata = 32'(data_q);
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/fcs_shifter.sv
module fcs_shifter
   import fcs_pkg::*;
#(
   parameter int unsigned MAX_TX     = 8,
   parameter int unsigned DATA_BYTES = 4,
   parameter int unsigned TXW        = 4,
   parameter int unsigned RXW        = 3,
   parameter int unsigned LANEW      = 2,
   parameter int unsigned BITW       = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic                  tick,
   input  logic [TXW-1:0]        tx_cnt,
   input  logic [RXW-1:0]        rx_cnt,
   input  logic [8*MAX_TX-1:0]   tx_stream,
   input  logic                  miso,
   output logic                  sck,
   output logic                  cs_n,
   output logic                  mosi,
   output logic                  busy,
   output logic                  lane_we,
   output logic [LANEW-1:0]      lane_idx,
   output logic [7:0]            lane_byte
);

   localparam int unsigned BYW  = BITW - 3;
   localparam int unsigned PADW = 2 ** BITW;

   shift_state_e       state_q;
   logic [BITW-1:0]    bit_q;
   logic [6:0]         rx_sh;
   logic [BYW-1:0]     byte_idx, frame_bytes, rx_pos;
   logic [BITW-1:0]    last_bit, sel;
   logic               in_tx;
   logic [PADW-1:0]    stream_pad;

   assign stream_pad  = PADW'(tx_stream);
   assign byte_idx    = bit_q[BITW-1:3];
   assign frame_bytes = BYW'(tx_cnt) + BYW'(rx_cnt);
   assign last_bit    = {frame_bytes - 1'b1, 3'b111};
   assign in_tx       = byte_idx < BYW'(tx_cnt);
   assign rx_pos      = byte_idx - BYW'(tx_cnt);
   assign sel         = {byte_idx, 3'b111 - bit_q[2:0]};
   assign busy        = (state_q != SH_IDLE);
   assign mosi        = busy && in_tx && stream_pad[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SH_IDLE;
         bit_q     <= '0;
         sck       <= 1'b0;
         cs_n      <= 1'b1;
         rx_sh     <= '0;
         lane_we   <= 1'b0;
         lane_idx  <= '0;
         lane_byte <= '0;
      end else begin
         lane_we <= 1'b0;
         case (state_q)
            SH_IDLE: begin
               if (go) begin
                  state_q <= SH_LOW;
                  cs_n    <= 1'b0;
                  bit_q   <= '0;
               end
            end
            SH_LOW: begin
               if (tick) begin
                  state_q <= SH_HIGH;
                  sck     <= 1'b1;
                  if (!in_tx) begin
                     rx_sh <= {rx_sh[5:0], miso};
                     if (bit_q[2:0] == 3'd7) begin
                        lane_we   <= 1'b1;
                        lane_idx  <= rx_pos[LANEW-1:0];
                        lane_byte <= {rx_sh, miso};
                     end
                  end
               end
            end
            SH_HIGH: begin
               if (tick) begin
                  sck <= 1'b0;
                  if (bit_q == last_bit) begin
                     state_q <= SH_TAIL;
                  end else begin
                     state_q <= SH_LOW;
                     bit_q   <= bit_q + 1'b1;
                  end
               end
            end
            SH_TAIL: begin
               if (tick) begin
                  state_q <= SH_IDLE;
                  cs_n    <= 1'b1;
               end
            end
            default: state_q <= SH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_cmd_shifter.sv
module flash_cmd_shifter
   import fcs_pkg::*;
#(
   parameter int unsigned HALF_DIV   = 2,
   parameter int unsigned ADDR_BYTES = 3,
   parameter int unsigned DATA_BYTES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        spi_sck,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso
);

   localparam int unsigned MAX_TX = 1 + ADDR_BYTES + DATA_BYTES;
   localparam int unsigned TXW    = $clog2(MAX_TX + 1);
   localparam int unsigned RXW    = $clog2(DATA_BYTES + 1);
   localparam int unsigned LANEW  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
   localparam int unsigned BITW   = $clog2(8 * (MAX_TX + DATA_BYTES) + 1);
   localparam int unsigned CMDW   = 8 * (1 + ADDR_BYTES);
   localparam int unsigned DATW   = 8 * DATA_BYTES;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (ADDR_BYTES < 1 || ADDR_BYTES > 3) begin : g_bad_addr
         $error("ADDR_BYTES must lie in 1..3");
      end
      if (DATA_BYTES < 1 || DATA_BYTES > 4) begin : g_bad_data
         $error("DATA_BYTES must lie in 1..4");
      end
      if (TXW > F_CNT_W || RXW > F_CNT_W) begin : g_bad_field
         $error("count field too narrow");
      end
   endgenerate

   logic                go, busy_flag, eng_busy, tick;
   logic [TXW-1:0]      tx_cnt;
   logic [RXW-1:0]      rx_cnt;
   logic [CMDW-1:0]     cmd_q;
   logic [DATW-1:0]     data_q;
   logic                lane_we;
   logic [LANEW-1:0]    lane_idx;
   logic [7:0]          lane_byte;
   logic [8*MAX_TX-1:0] tx_stream;

   // byte 0: command, then address high to low, then data low to high
   assign tx_stream[7:0] = cmd_q[7:0];
   generate
      for (genvar a = 1; a <= ADDR_BYTES; a++) begin : g_addr
         assign tx_stream[8*a +: 8] = cmd_q[8*(ADDR_BYTES - a + 1) +: 8];
      end
      for (genvar d = 0; d < DATA_BYTES; d++) begin : g_data
         assign tx_stream[8*(1 + ADDR_BYTES + d) +: 8] = data_q[8*d +: 8];
      end
   endgenerate

   fcs_regfile #(
      .ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES), .MAX_TX(MAX_TX),
      .TXW(TXW), .RXW(RXW), .LANEW(LANEW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .eng_busy(eng_busy),
      .busy_flag(busy_flag), .go(go), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
      .cmd_q(cmd_q), .data_q(data_q), .lane_we(lane_we),
      .lane_idx(lane_idx), .lane_byte(lane_byte)
   );

   fcs_halfclk #(.HALF_DIV(HALF_DIV)) u_half (
      .clk(clk), .rst_n(rst_n), .run(eng_busy), .tick(tick)
   );

   fcs_shifter #(
      .MAX_TX(MAX_TX), .DATA_BYTES(DATA_BYTES), .TXW(TXW), .RXW(RXW),
      .LANEW(LANEW), .BITW(BITW)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .go(go), .tick(tick), .tx_cnt(tx_cnt),
      .rx_cnt(rx_cnt), .tx_stream(tx_stream), .miso(spi_miso),
      .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .busy(eng_busy),
      .lane_we(lane_we), .lane_idx(lane_idx), .lane_byte(lane_byte)
   );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
   import fcs_pkg::*;
#(
   parameter int unsigned MAX_TX     = 8,
   parameter int unsigned DATA_BYTES = 4,
   parameter int unsigned TXW        = 4,
   parameter int unsigned RXW        = 3,
   parameter int unsigned LANEW      = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sck,
   input logic             cs_n,
   input logic             mosi,
   input logic             busy_flag,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [TXW-1:0]   tx_cnt,
   input logic [RXW-1:0]   rx_cnt,
   input logic             lane_we,
   input logic [LANEW-1:0] lane_idx
);

   // R4: clock only toggles inside a frame
   p_sck_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   // R4: data line holds while the clock is high
   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R2: chip select low implies the busy flag
   p_cs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy_flag);

   // R8: a write during busy leaves the counts alone
   p_busy_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && busy_flag) |=> ($stable(tx_cnt) && $stable(rx_cnt)));

   // R7: stored counts never exceed their limits
   p_count_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(tx_cnt) <= MAX_TX) && (32'(rx_cnt) <= DATA_BYTES));

   // R6: reply lanes stay below the receive count
   p_lane_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we |-> (RXW'(lane_idx) < rx_cnt));

   // R9: a launch with empty counts leaves the engine idle
   p_zero_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy_flag && reg_addr == RA_CTRL && reg_wdata[F_START]
       && reg_wdata[F_TX_LSB +: F_CNT_W] == '0
       && reg_wdata[F_RX_LSB +: F_CNT_W] == '0) |=> !busy_flag);

endmodule

bind flash_cmd_shifter fcs_checker #(
   .MAX_TX(MAX_TX), .DATA_BYTES(DATA_BYTES), .TXW(TXW), .RXW(RXW), .LANEW(LANEW)
) u_fcs_chk (
   .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
   .busy_flag(busy_flag), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
   .lane_we(lane_we), .lane_idx(lane_idx)
);

// File: tb/flash_cmd_shifter_bench.sv
module flash_cmd_shifter_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int HALF = 2;
   localparam int NV   = 6;

   typedef struct packed {
      logic [3:0]  tx;
      logic [3:0]  rx;
      logic [31:0] cmd;
      logic [31:0] data;
      logic [31:0] reply;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{4'd1, 4'd3, 32'h0000009F, 32'hAABBCCDD, 32'h001720EF, 32'hAA1720EF},
      '{4'd4, 4'd4, 32'h12345603, 32'h00000000, 32'h44332211, 32'h44332211},
      '{4'd8, 4'd0, 32'h00010002, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF},
      '{4'd2, 4'd1, 32'h00000001, 32'h5A5A5A3C, 32'h00000081, 32'h5A5A5A81},
      '{4'd1, 4'd0, 32'h00000006, 32'h01020304, 32'h00000000, 32'h01020304},
      '{4'd5, 4'd2, 32'hC0FFEE02, 32'h0000A5F0, 32'h00007E3C, 32'h00007E3C}
   };

   logic        clk = 0, rst_n = 0;
   logic        reg_wr = 0;
   logic [1:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 0;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   // target model state
   int          sl_tx = 0, sl_rx = 0, nrise = 0;
   logic [31:0] sl_reply = 0;
   logic [7:0]  cap [16];
   int          t_cs_fall, t_first_rise, t_first_fall, t_last_fall, t_cs_rise;

   flash_cmd_shifter #(.HALF_DIV(HALF)) u_flash_cmd_shifter (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   initial forever #2.5 clk = ~clk;
   initial forever begin @(posedge clk); cyc++; end

   function automatic logic out_bit(int k);
      int j;
      j = k / 8 - sl_tx;
      if (j < 0 || j >= sl_rx) return 1'b0;
      return sl_reply[8*j + 7 - (k % 8)];
   endfunction

   // serial target: shifts in on rise, presents reply bits on fall
   initial begin
      logic prev_cs, prev_sck;
      prev_cs = 1; prev_sck = 0;
      for (int i = 0; i < 16; i++) cap[i] = 0;
      forever begin
         @(spi_cs_n or spi_sck);
         if (!spi_cs_n && prev_cs) begin
            nrise = 0; t_cs_fall = cyc;
            for (int i = 0; i < 16; i++) cap[i] = 0;
            spi_miso = out_bit(0);
         end
         if (spi_cs_n && !prev_cs) t_cs_rise = cyc;
         if (!spi_cs_n && spi_sck && !prev_sck) begin
            if (nrise == 0) t_first_rise = cyc;
            if (nrise < 128) cap[nrise/8] = {cap[nrise/8][6:0], spi_mosi};
            nrise++;
         end
         if (!spi_cs_n && !spi_sck && prev_sck) begin
            t_last_fall = cyc;
            if (nrise == 1) t_first_fall = cyc;
            spi_miso = out_bit(nrise);
         end
         prev_cs = spi_cs_n; prev_sck = spi_sck;
      end
   end

   task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      reg_addr = 2'd0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (!reg_rdata[16]) break;
      end
   endtask

   function automatic logic [7:0] exp_byte(logic [31:0] cmd, logic [31:0] data, int k);
      if (k == 0) return cmd[7:0];
      if (k <= 3) return cmd[8*(4-k) +: 8];
      return data[8*(k-4) +: 8];
   endfunction

   initial begin
      #(5ns * 150000);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog: actual hung expected idle");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(2'd0, v); check("R1 ctrl reset", v == 0, v, 0);
      rd(2'd1, v); check("R1 cmd reset", v == 0, v, 0);
      rd(2'd2, v); check("R1 data reset", v == 0, v, 0);
      check("R1 pins reset", spi_cs_n && !spi_sck && !spi_mosi,
            {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'h4);

      // table of frames
      for (int n = 0; n < NV; n++) begin
         vec_t t;
         logic [31:0] bad;
         bit ok;
         t = VECS[n];
         sl_tx = int'(t.tx); sl_rx = int'(t.rx); sl_reply = t.reply;
         wr(2'd1, t.cmd);
         wr(2'd2, t.data);
         wr(2'd0, {23'd0, 1'b1, t.rx, t.tx});
         check("R2 busy after launch", reg_rdata[16] == 1'b1, reg_rdata, 32'h10000);
         wait_idle();
         ok = 1; bad = 0;
         for (int k = 0; k < sl_tx; k++)
            if (cap[k] != exp_byte(t.cmd, t.data, k)) begin
               ok = 0; bad = {cap[k], exp_byte(t.cmd, t.data, k), 16'(k)};
            end
         check("R3 R4 sent bytes", ok, bad, 0);
         ok = 1; bad = 0;
         for (int k = sl_tx; k < sl_tx + sl_rx; k++)
            if (cap[k] != 0) begin ok = 0; bad = 32'(cap[k]); end
         check("R5 mosi zero in reply", ok, bad, 0);
         check("R5 clock count", nrise == 8*(sl_tx+sl_rx), nrise, 8*(sl_tx+sl_rx));
         rd(2'd2, v); check("R6 reply lanes", v == t.exp, v, t.exp);
         check("R10 lead", t_first_rise - t_cs_fall == HALF, t_first_rise - t_cs_fall, HALF);
         check("R10 high phase", t_first_fall - t_first_rise == HALF,
               t_first_fall - t_first_rise, HALF);
         check("R10 trail", t_cs_rise - t_last_fall == HALF, t_cs_rise - t_last_fall, HALF);
      end

      // R7 clamp, no launch
      wr(2'd0, 32'h0000_009F);
      rd(2'd0, v); check("R7 clamp", v == 32'h48, v, 32'h48);

      // R9 empty launch
      nrise = 0;
      wr(2'd0, 32'h0000_0100);
      check("R9 not busy", reg_rdata[16] == 1'b0, reg_rdata, 0);
      repeat (10) @(negedge clk);
      check("R9 cs idle", spi_cs_n && nrise == 0, {31'd0, spi_cs_n}, 1);

      // R8 writes during busy
      sl_tx = 1; sl_rx = 1; sl_reply = 32'h000000C3;
      wr(2'd1, 32'h00000005);
      wr(2'd2, 32'h99887766);
      wr(2'd0, 32'h0000_0111);
      wr(2'd0, 32'h0000_0123);
      wr(2'd2, 32'h11111111);
      wr(2'd1, 32'h22222222);
      wait_idle();
      repeat (20) @(negedge clk);
      check("R8 single frame", nrise == 16, nrise, 16);
      rd(2'd0, v); check("R8 counts kept", v == 32'h11, v, 32'h11);
      rd(2'd1, v); check("R8 cmd kept", v == 32'h05, v, 32'h05);
      rd(2'd2, v); check("R8 R6 data kept", v == 32'h998877C3, v, 32'h998877C3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule